// File: doc/BRIEF.md
# Retrace-Window Housekeeping Phase Sequencer

This block generates the strobe timing for the housekeeping engine of a character video terminal. While the display is being scanned the engine stays idle. When vertical retrace begins, the block turns the running 3-bit scan-row count into eight one-hot phase strobes. Each strobe has a fixed job. Phase 0 carries memory access. Phase 1 carries counting. Phase 2 carries the scroll check. Phases 3 to 6 form the erase window. Phase 7 wraps up the cycle. One pass through the eight rows is one housekeeping cycle, and retrace holds eight such cycles. The access, count, scroll and wrap-up phases are further split into four sub-strobes, which come from two low bits of the horizontal character count.

Incoming work can back up faster than retrace can absorb it. To handle that, the block looks at a pending request at each row 7 to row 0 boundary. If the request is still high once retrace has ended, the block keeps running cycles into display time, starting again from phase 0. It also raises a refresh-inhibit flag. That flag stays up until the next retrace begins, so refresh comes back only with a fresh frame. Every register advances only on clock edges where the character clock enable is high. The block has no streaming data path, so all of its pins are plain control and status.

Top module: `hk_phase_seq`

## Requirements
- R1: After reset, all strobes, sub-strobes, `erase_win`, `busy`, `ext_cycle` and `refresh_off` are 0, and `hk_cycle` is 0.
- R2: The block is active on an enabled edge when `vretrace` is high there or the extended state stays set there. After an enabled edge where it is not active, `phase_stb` is 0 and `busy` is 0. After an active one, `busy` is 1.
- R3: After an active enabled edge, `phase_stb` is one-hot, with bit n set where n is the `scan_row` value sampled at that edge.
- R4: Sub-strobe buses `acc_sub`, `cnt_sub`, `scr_sub` and `wrap_sub` belong to phases 0, 1, 2 and 7. Bit j of a bus is 1 exactly when its phase strobe is set and the sampled `hchar` equals j. Otherwise every bit is 0.
- R5: `erase_win` is 1 exactly when a strobe from phase 3 to phase 6 is set.
- R6: A clock edge with `char_ce` low changes no output.
- R7: `hk_cycle` is cleared on the enabled edge where `vretrace` is first seen high. It then increments at each active boundary, meaning an edge where the previously sampled row was 7 and the sampled row is 0.
- R8: At a boundary with `vretrace` low, the block enters extended state if it was active at the previous sample and `in_pend` is high. It then sets `ext_cycle` and strobes phase 0.
- R9: At a boundary in extended state with `in_pend` low and `vretrace` low, `ext_cycle` clears and the strobes stop.
- R10: `refresh_off` is set together with `ext_cycle`. It stays set after extended state ends and clears only on an enabled edge with `vretrace` high.
- R11: An enabled edge with `vretrace` high clears `ext_cycle`, and normal retrace cycles go on.
- R12: In extended state, `in_pend` is ignored on edges that are not boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_ce | input | 1 | Character clock enable |
| scan_row | input | 3 | Scan-row count, selects the phase |
| hchar | input | 2 | Low horizontal character count bits, select the sub-strobe |
| vretrace | input | 1 | Vertical retrace flag |
| in_pend | input | 1 | Incoming work still pending |
| phase_stb | output | 8 | One-hot phase strobes |
| acc_sub | output | 4 | Phase 0 sub-strobes |
| cnt_sub | output | 4 | Phase 1 sub-strobes |
| scr_sub | output | 4 | Phase 2 sub-strobes |
| wrap_sub | output | 4 | Phase 7 sub-strobes |
| erase_win | output | 1 | Erase window, phases 3 to 6 |
| busy | output | 1 | Housekeeping strobes running |
| ext_cycle | output | 1 | Extended cycle in progress |
| refresh_off | output | 1 | Display refresh inhibited until next retrace |
| hk_cycle | output | 3 | Housekeeping cycle index |

## Verification
The bench targets the edge where retrace falls while work is pending. A design that sampled the request at the wrong point, or lost the retrace history, would stop the strobes instead of restarting at phase 0. It also drives frames where the request stays high all through display. Here a design that does not hand back to retrace would keep `ext_cycle` set or fail to clear `refresh_off`. Request pulses are placed in the middle of extended cycles to catch a design that ends those cycles early. Long runs with the clock enable low expose any register that advances without it.

// File: rtl/hk_pkg.sv
package hk_pkg;
  localparam int SPLIT_N = 4;

  function automatic int split_phase(input int idx, input int nph);
    return (idx < SPLIT_N - 1) ? idx : nph - 1;
  endfunction
endpackage

// File: rtl/hk_row_track.sv
module hk_row_track #(
  parameter int PH_W  = 3,
  parameter int CYC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic [PH_W-1:0]  row,
  input  logic             ret,
  input  logic             ext_n,
  output logic             bnd,
  output logic             ret_q,
  output logic [CYC_W-1:0] cyc
);
  logic [PH_W-1:0]  prev_q;
  logic [CYC_W-1:0] cyc_q;

  // a row wrap from the last phase back to phase 0 closes a cycle
  assign bnd = (prev_q == {PH_W{1'b1}}) && (row == '0);
  assign cyc = cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      ret_q  <= 1'b0;
      cyc_q  <= '0;
    end else if (ce) begin
      prev_q <= row;
      ret_q  <= ret;
      if (ret && !ret_q)
        cyc_q <= '0;
      else if (bnd && (ret || ext_n))
        cyc_q <= cyc_q + 1'b1;
    end
  end
endmodule

// File: rtl/hk_ext_ctl.sv
module hk_ext_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic ret,
  input  logic ret_q,
  input  logic bnd,
  input  logic pend,
  output logic ext_n,
  output logic ext_q,
  output logic roff_q
);
  always_comb begin
    if (ret)
      ext_n = 1'b0;
    else if (bnd)
      ext_n = (ret_q || ext_q) && pend;
    else
      ext_n = ext_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q  <= 1'b0;
      roff_q <= 1'b0;
    end else if (ce) begin
      ext_q  <= ext_n;
      roff_q <= ret ? 1'b0 : (roff_q | ext_n);
    end
  end
endmodule

// File: rtl/hk_strobe_dec.sv
module hk_strobe_dec #(
  parameter int PH_W     = 3,
  parameter int SUB_W    = 2,
  parameter int ERASE_LO = 3,
  parameter int ERASE_HI = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ce,
  input  logic                          en,
  input  logic [PH_W-1:0]               row,
  input  logic [SUB_W-1:0]              hc,
  output logic [(1<<PH_W)-1:0]          phase,
  output logic [hk_pkg::SPLIT_N*(1<<SUB_W)-1:0] sub,
  output logic                          erase,
  output logic                          busy
);
  localparam int NPH  = 1 << PH_W;
  localparam int NSUB = 1 << SUB_W;

  logic [NPH-1:0]  ph_oh;
  logic [NSUB-1:0] hc_oh;

  assign ph_oh = en ? (NPH'(1) << row) : '0;
  assign hc_oh = NSUB'(1) << hc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      erase <= 1'b0;
      busy  <= 1'b0;
    end else if (ce) begin
      phase <= ph_oh;
      erase <= en && (int'(row) >= ERASE_LO) && (int'(row) <= ERASE_HI);
      busy  <= en;
    end
  end

  for (genvar i = 0; i < hk_pkg::SPLIT_N; i++) begin : g_split
    localparam int PIDX = hk_pkg::split_phase(i, NPH);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sub[i*NSUB +: NSUB] <= '0;
      else if (ce)
        sub[i*NSUB +: NSUB] <= ph_oh[PIDX] ? hc_oh : '0;
    end
  end
endmodule

// File: rtl/hk_phase_seq.sv
module hk_phase_seq #(
  parameter int PH_W     = 3,
  parameter int SUB_W    = 2,
  parameter int CYC_W    = 3,
  parameter int ERASE_LO = 3,
  parameter int ERASE_HI = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   char_ce,
  input  logic [PH_W-1:0]        scan_row,
  input  logic [SUB_W-1:0]       hchar,
  input  logic                   vretrace,
  input  logic                   in_pend,
  output logic [(1<<PH_W)-1:0]   phase_stb,
  output logic [(1<<SUB_W)-1:0]  acc_sub,
  output logic [(1<<SUB_W)-1:0]  cnt_sub,
  output logic [(1<<SUB_W)-1:0]  scr_sub,
  output logic [(1<<SUB_W)-1:0]  wrap_sub,
  output logic                   erase_win,
  output logic                   busy,
  output logic                   ext_cycle,
  output logic                   refresh_off,
  output logic [CYC_W-1:0]       hk_cycle
);
  localparam int NSUB = 1 << SUB_W;

  logic bnd, ret_q, ext_n;
  logic [hk_pkg::SPLIT_N*NSUB-1:0] sub_all;

  hk_row_track #(.PH_W(PH_W), .CYC_W(CYC_W)) u_track (
    .clk(clk), .rst_n(rst_n), .ce(char_ce), .row(scan_row), .ret(vretrace),
    .ext_n(ext_n), .bnd(bnd), .ret_q(ret_q), .cyc(hk_cycle)
  );

  hk_ext_ctl u_ext (
    .clk(clk), .rst_n(rst_n), .ce(char_ce), .ret(vretrace), .ret_q(ret_q),
    .bnd(bnd), .pend(in_pend), .ext_n(ext_n), .ext_q(ext_cycle),
    .roff_q(refresh_off)
  );

  hk_strobe_dec #(.PH_W(PH_W), .SUB_W(SUB_W), .ERASE_LO(ERASE_LO),
                  .ERASE_HI(ERASE_HI)) u_dec (
    .clk(clk), .rst_n(rst_n), .ce(char_ce), .en(vretrace || ext_n),
    .row(scan_row), .hc(hchar), .phase(phase_stb), .sub(sub_all),
    .erase(erase_win), .busy(busy)
  );

  assign acc_sub  = sub_all[0*NSUB +: NSUB];
  assign cnt_sub  = sub_all[1*NSUB +: NSUB];
  assign scr_sub  = sub_all[2*NSUB +: NSUB];
  assign wrap_sub = sub_all[3*NSUB +: NSUB];
endmodule

// File: rtl/hk_seq_chk.sv
module hk_seq_chk #(
  parameter int NPH  = 8,
  parameter int NSUB = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            char_ce,
  input logic [NPH-1:0]  phase_stb,
  input logic [NSUB-1:0] acc_sub,
  input logic [NSUB-1:0] wrap_sub,
  input logic            erase_win,
  input logic            busy,
  input logic            ext_cycle,
  input logic            refresh_off
);
  a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $onehot(phase_stb));
  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (phase_stb == '0));
  a_r4_acc_sub: assert property (@(posedge clk) disable iff (!rst_n)
    (|acc_sub) |-> (phase_stb[0] && $onehot(acc_sub)));
  a_r4_wrap_sub: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap_sub) |-> phase_stb[NPH-1]);
  a_r5_erase: assert property (@(posedge clk) disable iff (!rst_n)
    erase_win |-> (|phase_stb[6:3]));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !char_ce |=> ($stable(phase_stb) && $stable(ext_cycle)));
  a_r8_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_cycle) |-> phase_stb[0]);
  a_r10_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cycle |-> refresh_off);
endmodule

bind hk_phase_seq hk_seq_chk #(.NPH(1 << PH_W), .NSUB(1 << SUB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .char_ce(char_ce), .phase_stb(phase_stb),
  .acc_sub(acc_sub), .wrap_sub(wrap_sub), .erase_win(erase_win),
  .busy(busy), .ext_cycle(ext_cycle), .refresh_off(refresh_off)
);

// File: tb/tb_hk_phase_seq.sv
module tb_hk_phase_seq;
  localparam int CLK_P   = 10;
  localparam int ROWLEN  = 3;
  localparam int DISP    = 16;
  localparam int FRAME   = 80;
  localparam int NFRAMES = 40;

  logic clk = 1'b0, rst_n = 1'b0, char_ce = 1'b0, vretrace = 1'b0, in_pend = 1'b0;
  logic [2:0] scan_row = '0;
  logic [1:0] hchar = '0;
  logic [7:0] phase_stb;
  logic [3:0] acc_sub, cnt_sub, scr_sub, wrap_sub;
  logic erase_win, busy, ext_cycle, refresh_off;
  logic [2:0] hk_cycle;

  hk_phase_seq dut (.*);

  always #(CLK_P/2) clk = ~clk;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // reference model state
  logic [2:0] m_prev, m_cyc;
  logic m_retq, m_ext, m_roff, m_busy, m_erase;
  logic [7:0] m_ph;
  logic [3:0] m_sub [4];
  bit f_r11, f_r12;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] sub_exp(input logic [7:0] ph, input int p, input logic [1:0] h);
    return ph[p] ? (4'b1 << h) : 4'b0;
  endfunction

  task automatic model_reset();
    m_prev = '0; m_cyc = '0; m_retq = 0; m_ext = 0; m_roff = 0;
    m_busy = 0; m_erase = 0; m_ph = '0;
    for (int i = 0; i < 4; i++) m_sub[i] = '0;
    f_r11 = 0; f_r12 = 0;
  endtask

  task automatic model_edge(input logic ce, input logic [2:0] r, input logic [1:0] h,
                            input logic ret, input logic pend);
    logic bnd, en, ext_n;
    int sp [4];
    sp = '{0, 1, 2, 7};
    f_r11 = 0; f_r12 = 0;
    if (!ce) return;
    bnd = (m_prev == 3'd7) && (r == 3'd0);
    if (ret) ext_n = 0;
    else if (bnd) ext_n = (m_retq || m_ext) && pend;
    else ext_n = m_ext;
    f_r11 = ret && m_ext;
    f_r12 = m_ext && !ret && !bnd && !pend;
    en = ret || ext_n;
    if (ret && !m_retq) m_cyc = '0;
    else if (bnd && en) m_cyc = m_cyc + 3'd1;
    m_roff = ret ? 1'b0 : (m_roff | ext_n);
    m_ext = ext_n;
    m_ph = en ? (8'b1 << r) : 8'b0;
    for (int i = 0; i < 4; i++) m_sub[i] = sub_exp(m_ph, sp[i], h);
    m_erase = en && (r >= 3) && (r <= 6);
    m_busy = en;
    m_prev = r;
    m_retq = ret;
  endtask

  task automatic check_all(input logic last_ce, input logic [7:0] ph_before);
    chk(m_busy ? "R3 phase_stb" : "R2 phase_stb idle", phase_stb, m_ph);
    chk("R2 busy", busy, m_busy);
    chk("R4 acc_sub", acc_sub, m_sub[0]);
    chk("R4 cnt_sub", cnt_sub, m_sub[1]);
    chk("R4 scr_sub", scr_sub, m_sub[2]);
    chk("R4 wrap_sub", wrap_sub, m_sub[3]);
    chk("R5 erase_win", erase_win, m_erase);
    chk("R7 hk_cycle", hk_cycle, m_cyc);
    chk(m_ext ? "R8 ext_cycle" : "R9 ext_cycle", ext_cycle, m_ext);
    chk("R10 refresh_off", refresh_off, m_roff);
    if (!last_ce) chk("R6 hold without enable", phase_stb, ph_before);
    if (f_r11) chk("R11 retrace ends extended", ext_cycle, 0);
    if (f_r12) chk("R12 pend ignored mid-cycle", ext_cycle, 1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    int t, mode, k, pos;
    logic ce_v, last_ce;
    logic [7:0] ph_before;
    void'($urandom(32'h1d5e7));
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 phase_stb", phase_stb, 0);
    chk("R1 subs", {acc_sub, cnt_sub, scr_sub, wrap_sub}, 0);
    chk("R1 flags", {erase_win, busy, ext_cycle, refresh_off}, 0);
    chk("R1 hk_cycle", hk_cycle, 0);
    rst_n = 1'b1;
    t = 0; mode = 0; k = 1; last_ce = 1'b1; ph_before = '0;
    while (t < NFRAMES * FRAME * ROWLEN) begin
      @(negedge clk);
      check_all(last_ce, ph_before);
      ph_before = phase_stb;
      pos = (t / ROWLEN) % FRAME;
      if (pos == 0 && (t % ROWLEN) == 0) begin
        case ((t / ROWLEN) / FRAME)
          0: mode = 0;
          1: begin mode = 2; k = 1; end
          2: mode = 3;
          3: begin mode = 2; k = 2; end
          4: mode = 1;
          default: begin mode = $urandom_range(0, 3); k = $urandom_range(1, 2); end
        endcase
      end
      ce_v = ($urandom_range(0, 3) != 0);
      char_ce  = ce_v;
      scan_row = 3'((t / ROWLEN) % 8);
      hchar    = 2'(t % 4);
      vretrace = (pos >= DISP);
      case (mode)
        0: in_pend = 1'b0;
        1: in_pend = ($urandom_range(0, 1) == 1);
        2: in_pend = (pos >= DISP - 1) || (pos < 8 * k - 1) || (pos >= 8 * k && $urandom_range(0, 1) == 1 && pos % 8 != 0);
        default: in_pend = 1'b1;
      endcase
      model_edge(ce_v, scan_row, hchar, vretrace, in_pend);
      last_ce = ce_v;
      if (ce_v) t++;
      @(posedge clk);
    end
    @(negedge clk);
    check_all(last_ce, ph_before);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule